// File: doc/BRIEF.md
# Three-Input Bitwise Lookup Vector Unit

This unit evaluates any Boolean function of three inputs on every bit of a 512-bit vector. At each bit position the bits taken from sources A, B and C form a 3-bit index, and that index selects one bit of an 8-bit function code. The selected bit is the result bit. Each of the 256 codes is a different function, so one operation can stand in for a chain of AND, OR, XOR and NOT steps.

The vector is divided into 32-bit or 64-bit elements, and a write mask applies per element. When a lane is masked off, merge mode keeps that element of source A, which is also the destination operand, and zero mode clears it. A mask selector of zero turns masking off. The result is registered: an operation accepted on one clock edge shows its result with a valid strobe after that edge, and a new operation can be accepted on every cycle.

Top module: `tern_logic_unit`

## Requirements
- R1: In every element that is written, result bit k equals funcCode[{srcA[k], srcB[k], srcC[k]}], with srcA as the index MSB and srcC as the LSB. Code 8'hF0 gives srcA, 8'hCC gives srcB and 8'hAA gives srcC.
- R2: All 256 function codes give the function that R1 defines. None of them is reserved or treated as a special case.
- R3: With elemWide=0 (32-bit elements), maskBits[i] enables result bits [32i+31:32i] for i = 0..15.
- R4: With elemWide=1 (64-bit elements), maskBits[j] enables result bits [64j+63:64j] for j = 0..7, and maskBits[15:8] have no effect.
- R5: With maskSel equal to 0, every element is written and maskBits have no effect.
- R6: With zeroMode=0 (merge), a masked-off element of the result equals the same element of srcA.
- R7: With zeroMode=1, a masked-off element of the result is all zeros.
- R8: An operation accepted on a clock edge (inValid and inReady both high) raises outValid for exactly the following cycle and presents its result there. Back-to-back operations each appear one cycle after acceptance.
- R9: During reset and after it, outValid is 0 and result is 0 until an operation is accepted. inReady is 0 while reset is held and 1 from the first cycle after reset.
- R10: On a cycle with no accepted operation, result keeps its previous value and outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation request |
| inReady | output | 1 | Unit can accept an operation |
| srcA | input | 512 | First source; also the destination value used for merging |
| srcB | input | 512 | Second source |
| srcC | input | 512 | Third source |
| funcCode | input | 8 | Truth table indexed by {A,B,C} |
| elemWide | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| maskSel | input | 3 | Mask register selector; 0 means unmasked |
| maskBits | input | 16 | Per-element write mask contents |
| zeroMode | input | 1 | 0: merge masked-off elements, 1: zero them |
| outValid | output | 1 | Result valid strobe |
| result | output | 512 | Registered result vector |

## Verification
The assertions assume that inValid, the operands and the mode inputs are at known levels whenever the clock rises outside reset. They also assume that reset is applied from time zero. The bench drives every input away from the clock edge and keeps inValid low through reset, so both assumptions hold. Random and directed operations, including an 8-deep back-to-back burst, cover the latency and hold rules.

// File: rtl/tern_logic_pkg.sv
package tern_logic_pkg;
  localparam int TL_VEC_W  = 512;
  localparam int TL_LANE_W = 32;
  localparam int TL_LANES  = TL_VEC_W / TL_LANE_W;
  localparam int TL_SEL_W  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result this edge
    logic zeroFill;  // masked-off lanes are cleared instead of merged
  } tl_strobe_t;
endpackage

// File: rtl/tern_logic_ctrl.sv
module tern_logic_ctrl
  import tern_logic_pkg::*;
#(
  parameter int LANES = TL_LANES,
  parameter int SEL_W = TL_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             elemWide,
  input  logic [SEL_W-1:0] maskSel,
  input  logic [LANES-1:0] maskBits,
  input  logic             zeroMode,
  output logic             inReady,
  output logic             outValid,
  output tl_strobe_t       strobe,
  output logic [LANES-1:0] laneEn
);
  logic readyQ;
  logic validQ;
  logic maskOff;

  assign maskOff = (maskSel == '0);

  // map element mask bits onto 32-bit lanes
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneEn[i] = maskOff | (elemWide ? maskBits[i/2] : maskBits[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= 1'b0;
      validQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      validQ <= inValid & readyQ;
    end
  end

  assign inReady         = readyQ;
  assign outValid        = validQ;
  assign strobe.load     = inValid & readyQ;
  assign strobe.zeroFill = zeroMode;
endmodule

// File: rtl/tern_logic_dp.sv
module tern_logic_dp
  import tern_logic_pkg::*;
#(
  parameter int VEC_W  = TL_VEC_W,
  parameter int LANE_W = TL_LANE_W,
  localparam int LANES = VEC_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  tl_strobe_t       strobe,
  input  logic [LANES-1:0] laneEn,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] srcC,
  input  logic [7:0]       funcCode,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0] lutOut;
  logic [VEC_W-1:0] nextRes;
  logic [VEC_W-1:0] resQ;

  for (genvar k = 0; k < VEC_W; k++) begin : g_bit
    assign lutOut[k] = funcCode[{srcA[k], srcB[k], srcC[k]}];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    logic [LANE_W-1:0] keepVal;
    assign keepVal = strobe.zeroFill ? '0 : srcA[l*LANE_W +: LANE_W];
    assign nextRes[l*LANE_W +: LANE_W] =
      laneEn[l] ? lutOut[l*LANE_W +: LANE_W] : keepVal;
  end

  always_ff @(posedge clk) begin
    if (rst)              resQ <= '0;
    else if (strobe.load) resQ <= nextRes;
  end

  assign result = resQ;
endmodule

// File: rtl/tern_logic_unit.sv
module tern_logic_unit
  import tern_logic_pkg::*;
#(
  parameter int VEC_W  = TL_VEC_W,
  parameter int LANE_W = TL_LANE_W,
  parameter int SEL_W  = TL_SEL_W,
  localparam int LANES = VEC_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] srcC,
  input  logic [7:0]       funcCode,
  input  logic             elemWide,
  input  logic [SEL_W-1:0] maskSel,
  input  logic [LANES-1:0] maskBits,
  input  logic             zeroMode,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  tl_strobe_t       strobe;
  logic [LANES-1:0] laneEn;

  tern_logic_ctrl #(.LANES(LANES), .SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .elemWide(elemWide),
    .maskSel(maskSel), .maskBits(maskBits), .zeroMode(zeroMode),
    .inReady(inReady), .outValid(outValid), .strobe(strobe), .laneEn(laneEn)
  );

  tern_logic_dp #(.VEC_W(VEC_W), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .laneEn(laneEn),
    .srcA(srcA), .srcB(srcB), .srcC(srcC), .funcCode(funcCode),
    .result(result)
  );
endmodule

// File: rtl/tern_logic_chk.sv
module tern_logic_chk #(
  parameter int VEC_W = 512,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic [VEC_W-1:0] srcA,
  input logic [7:0]       funcCode,
  input logic [SEL_W-1:0] maskSel,
  input logic             zeroMode,
  input logic             outValid,
  input logic [VEC_W-1:0] result
);
  logic take;
  assign take = inValid & inReady;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) take |=> outValid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !take |=> !outValid); // R10
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !take |=> $stable(result)); // R10
  AST_PASS_A: assert property (@(posedge clk) disable iff (rst)
    (take && funcCode == 8'hF0 && maskSel == '0) |=> (result == $past(srcA))); // R1
  AST_ZERO_FUNC: assert property (@(posedge clk) disable iff (rst)
    (take && funcCode == 8'h00 && (zeroMode || maskSel == '0)) |=> (result == '0)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!outValid && !inReady)); // R9
endmodule

bind tern_logic_unit tern_logic_chk #(.VEC_W(VEC_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .srcA(srcA),
  .funcCode(funcCode), .maskSel(maskSel), .zeroMode(zeroMode),
  .outValid(outValid), .result(result)
);

// File: tb/tern_logic_unit_tb_top.sv
`timescale 1ns/1ps
module tern_logic_unit_tb_top;
  localparam int VW = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [VW-1:0] srcA = '0, srcB = '0, srcC = '0;
  logic [7:0]    funcCode = '0;
  logic          elemWide = 1'b0;
  logic [2:0]    maskSel = '0;
  logic [15:0]   maskBits = '0;
  logic          zeroMode = 1'b0;
  logic          outValid;
  logic [VW-1:0] result;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tern_logic_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .srcA(srcA), .srcB(srcB), .srcC(srcC), .funcCode(funcCode),
    .elemWide(elemWide), .maskSel(maskSel), .maskBits(maskBits),
    .zeroMode(zeroMode), .outValid(outValid), .result(result)
  );

  function automatic logic [VW-1:0] rnd512();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] expectOp(logic [VW-1:0] a, logic [VW-1:0] b,
      logic [VW-1:0] c, logic [7:0] f, logic wide, logic [2:0] sel,
      logic [15:0] m, logic zf);
    logic [VW-1:0] r;
    for (int k = 0; k < VW; k++) begin
      logic en;
      logic [2:0] idx;
      en = (sel == 3'd0) || (wide ? m[k/64] : m[k/32]);
      idx = {a[k], b[k], c[k]};
      r[k] = en ? f[idx] : (zf ? 1'b0 : a[k]);
    end
    return r;
  endfunction

  task automatic chkVec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkBit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic setOp(logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c,
      logic [7:0] f, logic wide, logic [2:0] sel, logic [15:0] m, logic zf);
    srcA = a; srcB = b; srcC = c; funcCode = f;
    elemWide = wide; maskSel = sel; maskBits = m; zeroMode = zf;
    inValid = 1'b1;
  endtask

  // one operation: drive at negedge, check one cycle after acceptance
  task automatic runOp(string tag, logic [VW-1:0] a, logic [VW-1:0] b,
      logic [VW-1:0] c, logic [7:0] f, logic wide, logic [2:0] sel,
      logic [15:0] m, logic zf);
    logic [VW-1:0] exp;
    exp = expectOp(a, b, c, f, wide, sel, m, zf);
    setOp(a, b, c, f, wide, sel, m, zf);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chkBit({tag, " R8 outValid"}, outValid, 1'b1);
    chkVec(tag, result, exp);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b, c, held;
    logic [VW-1:0] qa[8], qb[8], qc[8];
    logic [7:0]    qf[8];
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    chkBit("R9 outValid in reset", outValid, 1'b0);
    chkBit("R9 inReady in reset", inReady, 1'b0);
    chkVec("R9 result in reset", result, '0);
    rst = 1'b0;
    @(negedge clk);
    chkBit("R9 inReady after reset", inReady, 1'b1);
    chkBit("R9 outValid after reset", outValid, 1'b0);

    a = rnd512(); b = rnd512(); c = rnd512();
    // R1 identity codes
    runOp("R1 code F0 gives A", a, b, c, 8'hF0, 1'b0, 3'd0, 16'h0, 1'b0);
    chkVec("R1 F0 equals A", result, a);
    runOp("R1 code CC gives B", a, b, c, 8'hCC, 1'b0, 3'd0, 16'h0, 1'b0);
    chkVec("R1 CC equals B", result, b);
    runOp("R1 code AA gives C", a, b, c, 8'hAA, 1'b0, 3'd0, 16'h0, 1'b0);
    chkVec("R1 AA equals C", result, c);
    runOp("R1 xor3 96", a, b, c, 8'h96, 1'b0, 3'd0, 16'h0, 1'b0);
    chkVec("R1 96 equals A^B^C", result, a ^ b ^ c);

    // R2 every function code
    for (int f = 0; f < 256; f++)
      runOp("R2 code sweep", rnd512(), rnd512(), rnd512(), 8'(f), 1'b0, 3'd0, 16'h0, 1'b0);

    // R3 32-bit masks, merge (R6) and zero (R7)
    runOp("R3 R6 32b merge 5A3C", a, b, c, 8'h3C, 1'b0, 3'd1, 16'h5A3C, 1'b0);
    runOp("R3 R7 32b zero 8001", a, b, c, 8'hE8, 1'b0, 3'd4, 16'h8001, 1'b1);
    runOp("R6 all masked merge", a, b, c, 8'h00, 1'b0, 3'd2, 16'h0000, 1'b0);
    chkVec("R6 fully masked equals A", result, a);
    runOp("R7 all masked zero", a, b, c, 8'hFF, 1'b1, 3'd7, 16'h0000, 1'b1);
    chkVec("R7 fully masked is zero", result, '0);

    // R4 64-bit masks, upper mask bits must not matter
    runOp("R4 64b low mask A5", a, b, c, 8'h5F, 1'b1, 3'd3, 16'h00A5, 1'b0);
    held = result;
    runOp("R4 64b upper bits ignored", a, b, c, 8'h5F, 1'b1, 3'd3, 16'hFFA5, 1'b0);
    chkVec("R4 upper mask bits no effect", result, held);
    runOp("R4 R7 64b zero 81", a, b, c, 8'h1E, 1'b1, 3'd5, 16'h3C81, 1'b1);

    // R5 selector zero ignores mask contents
    runOp("R5 sel0 mask zero", a, b, c, 8'hCA, 1'b0, 3'd0, 16'h0000, 1'b1);
    chkVec("R5 sel0 all written", result, expectOp(a, b, c, 8'hCA, 1'b0, 3'd0, 16'hFFFF, 1'b1));
    runOp("R5 sel0 64b zero", a, b, c, 8'hCA, 1'b1, 3'd0, 16'h0000, 1'b0);

    // R10 hold while idle
    held = result;
    srcA = rnd512(); srcB = rnd512(); funcCode = 8'h69;
    repeat (4) @(negedge clk);
    chkBit("R10 outValid idle", outValid, 1'b0);
    chkVec("R10 result held", result, held);

    // R8 back-to-back burst
    for (int i = 0; i < 8; i++) begin
      qa[i] = rnd512(); qb[i] = rnd512(); qc[i] = rnd512(); qf[i] = 8'($urandom);
    end
    for (int i = 0; i < 8; i++) begin
      setOp(qa[i], qb[i], qc[i], qf[i], 1'b0, 3'd0, 16'h0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chkBit("R8 burst outValid", outValid, 1'b1);
      chkVec("R8 burst result", result,
             expectOp(qa[i], qb[i], qc[i], qf[i], 1'b0, 3'd0, 16'h0, 1'b0));
    end
    inValid = 1'b0;
    @(negedge clk);
    chkBit("R8 strobe drops after burst", outValid, 1'b0);

    // random mix across all modes (R1..R7)
    for (int n = 0; n < 300; n++)
      runOp("R1 R3 R4 R6 R7 random", rnd512(), rnd512(), rnd512(), 8'($urandom),
            1'($urandom), 3'($urandom), 16'($urandom), 1'($urandom));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule